// File: doc/BRIEF.md
# Four-Channel Sigma-Delta Sinc3 Decimator

This block connects four isolated one-bit sigma-delta modulators to the rest of the chip. It divides the system clock to make a single modulator clock, drives that clock out to all four modulators, and samples each returned data line on the clock's rising edge. Each channel converts its bitstream into signed multi-bit samples. A third-order sinc decimator reduces the rate by 125. A following stage then adds four consecutive sinc3 outputs, so each result is the sum of four. The four channels carry bus voltage, grid current, grid voltage and filter-capacitor current, and all four run at the same time on the same timing.

Each result is a 24-bit two's-complement value placed in the top of a 32-bit word, and it comes with a one-cycle strobe for its channel. With an 80 MHz system clock and a divider of 8, the modulator clock is 10 MHz and results arrive at 20 kHz. A shared sequencer has three states. IDLE: disabled, with the clock held low and all filter state cleared. PRIME: the sinc3 pipeline is filling and its outputs are discarded. RUN: results are produced. The transitions are: IDLE to PRIME when enable is high; PRIME to RUN at the end of the second decimation period; and any state to IDLE whenever enable is low.

Top module: `sdm_sinc3_decim`

## Requirements
- R1: While enabled, `mclk_o` toggles with a period of DIV (8) system cycles: 4 cycles high, then 4 cycles low. Its first rising edge comes 4 system edges after running starts. Out of reset it is low.
- R2: Each data bit is taken at the system edge where `mclk_o` rises. A bit value of 1 counts as +1 and a value of 0 counts as -1.
- R3: Each sinc3 output equals 125³ times the mean of the input over its window. For an input that repeats every 5 bits and holds c ones per period, the reported result is 1 562 500 × (2c − 5).
- R4: Each result is the sum of four consecutive sinc3 outputs, so consecutive results are exactly 500 `mclk_o` rising edges apart.
- R5: The full-scale result is ±7 812 500. A constant-1 input gives +7 812 500 and a constant-0 input gives −7 812 500.
- R6: A result sits in bits [31:8] of its channel's word as two's complement, and bits [7:0] are zero. Channel k occupies `sample_o[32k+31:32k]`. Out of reset all words are zero.
- R7: The four channels filter independently. Each has its own bit in `valid_o`, and each strobe lasts exactly one system cycle.
- R8: The first two sinc3 outputs after enabling are discarded. The first strobe comes at the 750th `mclk_o` rising edge after enabling, and it carries a complete value.
- R9: If `en_i` is low at a system edge, that edge produces no result, clears all filter state and drives `mclk_o` low. While disabled, nothing is produced. Enabling again restarts priming, with the timing of R8.
- R10: The integrators wrap in two's complement, and results stay exact when a constant input runs long enough to overflow them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low stops and clears the block |
| sd_bit_i | input | NCH | One data bit per modulator, sampled at the rising edge of `mclk_o` |
| mclk_o | output | 1 | Modulator clock shared by all channels |
| sample_o | output | NCH*WORD_W | Per-channel result words, channel k at bits [32k+31:32k] |
| valid_o | output | NCH | Per-channel one-cycle result strobe |

## Verification
The disable path and the result path can land on the same system edge: a falling enable may arrive exactly on the edge where the fourth sinc3 output would complete and be reported. The bench counts 4000 system cycles from an observed strobe and drops enable so that it is first seen low on that emission edge. It then requires that no strobe appears and that the modulator clock stays low. After that, it re-enables and requires that the next result arrives after a full priming interval of 750 rising edges and carries the exact expected value.

// File: rtl/sdm_dec_pkg.sv
package sdm_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } dec_state_e;

    // Bits needed to hold +/-mag in two's complement
    function automatic int signed_bits(input longint mag);
        return $clog2(mag + 1) + 1;
    endfunction

endpackage

// File: rtl/sdm_clkgen.sv
module sdm_clkgen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mclk_o,
    output logic strobe_o
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_n;

    always_comb begin
        strobe_o = run_i && (cnt == CW'(HALF - 1));
        cnt_n    = (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            mclk_o <= 1'b0;
        end else if (!run_i) begin
            cnt    <= '0;
            mclk_o <= 1'b0;
        end else begin
            cnt    <= cnt_n;
            mclk_o <= (cnt_n >= CW'(HALF));
        end
    end

    // R2: the capture edge is the edge on which the modulator clock rises
    p_capture_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> $rose(mclk_o));

    // R9: a stopped block leaves the modulator clock low
    p_idle_clock_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mclk_o);

endmodule

// File: rtl/sdm_seq.sv
module sdm_seq
    import sdm_dec_pkg::*;
#(
    parameter int OSR     = 125,
    parameter int INTEG   = 4,
    parameter int DISCARD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic strobe_i,
    output logic run_o,
    output logic clr_o,
    output logic dec_o,
    output logic acc_o,
    output logic emit_o
);
    localparam int BW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int IW = (INTEG > 1) ? $clog2(INTEG) : 1;
    localparam int PW = $clog2(DISCARD + 1);

    dec_state_e    st;
    dec_state_e    st_n;
    logic [BW-1:0] bcnt;
    logic [IW-1:0] icnt;
    logic [PW-1:0] pcnt;
    logic          dec_end;

    assign dec_end = strobe_i && (bcnt == BW'(OSR - 1));

    // next-state logic
    always_comb begin
        st_n = st;
        if (!en_i) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  st_n = ST_PRIME;
                ST_PRIME: if (dec_end && (pcnt == PW'(DISCARD - 1))) st_n = ST_RUN;
                ST_RUN:   st_n = ST_RUN;
                default:  st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // outputs
    always_comb begin
        run_o  = en_i && (st != ST_IDLE);
        clr_o  = !run_o;
        dec_o  = dec_end;
        acc_o  = 1'b0;
        emit_o = 1'b0;
        unique case (st)
            ST_IDLE:  ;
            ST_PRIME: ;
            ST_RUN: begin
                acc_o  = dec_end;
                emit_o = dec_end && (icnt == IW'(INTEG - 1));
            end
            default:  ;
        endcase
    end

    // bit, priming and post-integration counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
            icnt <= '0;
            pcnt <= '0;
        end else if (clr_o) begin
            bcnt <= '0;
            icnt <= '0;
            pcnt <= '0;
        end else begin
            if (strobe_i) bcnt <= dec_end ? '0 : bcnt + BW'(1);
            if (dec_end && (st == ST_PRIME)) pcnt <= pcnt + PW'(1);
            if (acc_o) icnt <= emit_o ? '0 : icnt + IW'(1);
        end
    end

    // R8: nothing is accumulated before the discard count is complete
    p_primed_before_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> (pcnt == PW'(DISCARD)));

    // R9: a low enable always returns the sequencer to idle
    p_idle_after_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st == ST_IDLE));

endmodule

// File: rtl/sdm_sinc3_chan.sv
module sdm_sinc3_chan #(
    parameter int SINC_W     = 23,
    parameter int OUT_W      = 24,
    parameter int WORD_W     = 32,
    parameter int FULL_SCALE = 7812500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              strobe_i,
    input  logic              dec_i,
    input  logic              acc_i,
    input  logic              emit_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    localparam int PAD = WORD_W - OUT_W;
    localparam int EXT = OUT_W - SINC_W;
    localparam logic signed [OUT_W:0] FS_POS = (OUT_W + 1)'(FULL_SCALE);
    localparam logic signed [OUT_W:0] FS_NEG = -FS_POS;

    typedef logic signed [SINC_W-1:0] sw_t;
    typedef logic signed [OUT_W-1:0]  ow_t;

    sw_t x;
    sw_t int1, int2, int3;
    sw_t int1_n, int2_n, int3_n;
    sw_t dly1, dly2, dly3;
    sw_t cmb1, cmb2, cmb3;
    ow_t acc, cmb3_x, acc_sum;

    // integrator chain and combs, all in modular arithmetic
    always_comb begin
        x       = bit_i ? sw_t'(1) : sw_t'(-1);
        int1_n  = int1 + x;
        int2_n  = int2 + int1_n;
        int3_n  = int3 + int2_n;
        cmb1    = int3_n - dly1;
        cmb2    = cmb1 - dly2;
        cmb3    = cmb2 - dly3;
        cmb3_x  = {{EXT{cmb3[SINC_W-1]}}, cmb3};
        acc_sum = acc + cmb3_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int1    <= '0;
            int2    <= '0;
            int3    <= '0;
            dly1    <= '0;
            dly2    <= '0;
            dly3    <= '0;
            acc     <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else if (clr_i) begin
            int1    <= '0;
            int2    <= '0;
            int3    <= '0;
            dly1    <= '0;
            dly2    <= '0;
            dly3    <= '0;
            acc     <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (strobe_i) begin
                int1 <= int1_n;
                int2 <= int2_n;
                int3 <= int3_n;
            end
            if (dec_i) begin
                dly1 <= int3_n;
                dly2 <= cmb1;
                dly3 <= cmb2;
            end
            if (acc_i) begin
                if (emit_i) begin
                    word_o  <= {acc_sum, {PAD{1'b0}}};
                    acc     <= '0;
                    valid_o <= 1'b1;
                end else begin
                    acc <= acc_sum;
                end
            end
        end
    end

    // R7: each strobe lasts one cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5: a reported result never leaves the full-scale range
    p_within_fullscale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (($signed(word_o[WORD_W-1 -: OUT_W]) <= FS_POS) &&
                     ($signed(word_o[WORD_W-1 -: OUT_W]) >= FS_NEG)));

endmodule

// File: rtl/sdm_sinc3_decim.sv
module sdm_sinc3_decim
    import sdm_dec_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DIV    = 8,
    parameter int OSR    = 125,
    parameter int INTEG  = 4,
    parameter int OUT_W  = 24,
    parameter int WORD_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [NCH-1:0]          sd_bit_i,
    output logic                    mclk_o,
    output logic [NCH*WORD_W-1:0]   sample_o,
    output logic [NCH-1:0]          valid_o
);
    localparam int ORDER      = 3;
    localparam int DISCARD    = ORDER - 1;
    localparam int SINC_GAIN  = OSR * OSR * OSR;
    localparam int FULL_SCALE = SINC_GAIN * INTEG;
    localparam int SINC_W     = signed_bits(longint'(SINC_GAIN)) + 1;

    logic run, clr, strobe, dec, acc, emit;

    sdm_clkgen #(
        .DIV (DIV)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .mclk_o   (mclk_o),
        .strobe_o (strobe)
    );

    sdm_seq #(
        .OSR     (OSR),
        .INTEG   (INTEG),
        .DISCARD (DISCARD)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .strobe_i (strobe),
        .run_o    (run),
        .clr_o    (clr),
        .dec_o    (dec),
        .acc_o    (acc),
        .emit_o   (emit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        sdm_sinc3_chan #(
            .SINC_W     (SINC_W),
            .OUT_W      (OUT_W),
            .WORD_W     (WORD_W),
            .FULL_SCALE (FULL_SCALE)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr),
            .strobe_i (strobe),
            .dec_i    (dec),
            .acc_i    (acc),
            .emit_i   (emit),
            .bit_i    (sd_bit_i[g]),
            .word_o   (sample_o[g*WORD_W +: WORD_W]),
            .valid_o  (valid_o[g])
        );
    end

endmodule

// File: tb/sdm_sinc3_decim_test.sv
module sdm_sinc3_decim_test;
    localparam int NCH   = 4;
    localparam int OSR   = 125;
    localparam int INTEG = 4;
    localparam int FIRST_RISES = 3 * OSR + OSR * INTEG - OSR;  // 750
    localparam int RES_RISES   = OSR * INTEG;                  // 500
    localparam int RES_CYCLES  = RES_RISES * 8;                // 4000

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic [NCH-1:0]   sd_bit;
    logic             mclk;
    logic [NCH*32-1:0] sample;
    logic [NCH-1:0]   valid;

    int  checks = 0;
    int  fails  = 0;
    int  rise_cnt = 0;
    int  last_rise = 0;
    bit  first_pend = 1'b0;
    bit  prev_any = 1'b0;
    int  bidx = 0;
    int  pat [NCH];
    string cur_tag = "R3";
    logic [NCH*24-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    sdm_sinc3_decim uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .sd_bit_i (sd_bit),
        .mclk_o   (mclk),
        .sample_o (sample),
        .valid_o  (valid)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic pbit(input int mask, input int k);
        return logic'((mask >> (k % 5)) & 1);
    endfunction

    // period-5 pattern with c ones: result = INTEG*OSR^3*(2c-5)/5
    function automatic int expv(input int mask);
        int c;
        c = $countones(mask[4:0]);
        return (INTEG * OSR * OSR * OSR / 5) * (2 * c - 5);
    endfunction

    task automatic apply_bits();
        for (int ch = 0; ch < NCH; ch++) sd_bit[ch] = pbit(pat[ch], bidx);
    endtask

    task automatic start(input int m0, input int m1, input int m2, input int m3);
        pat[0] = m0; pat[1] = m1; pat[2] = m2; pat[3] = m3;
        bidx = 0;
        apply_bits();
        rise_cnt   = 0;
        first_pend = 1'b1;
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic push_exp(input int n);
        for (int i = 0; i < n; i++) begin
            logic [NCH*24-1:0] item;
            for (int ch = 0; ch < NCH; ch++) item[ch*24 +: 24] = 24'(expv(pat[ch]));
            exp_q.push_back(item);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // modulator model: next bit presented after each falling clock edge (R2)
    initial begin
        forever begin
            @(negedge mclk);
            bidx++;
            apply_bits();
        end
    end

    initial begin
        forever begin
            @(posedge mclk);
            rise_cnt++;
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (valid != '0)) begin
                chk(valid == '1, "R7", "channel strobes together", valid, 15);
                chk(!prev_any, "R7", "strobe width one cycle", 2, 1);
                for (int ch = 0; ch < NCH; ch++)
                    chk(sample[ch*32 +: 8] == 8'h00, "R6", "low byte zero",
                        sample[ch*32 +: 8], 0);
                if (first_pend) begin
                    chk(rise_cnt == FIRST_RISES, "R8", "first result edge",
                        rise_cnt, FIRST_RISES);
                    first_pend = 1'b0;
                end else begin
                    chk(rise_cnt - last_rise == RES_RISES, "R4", "result spacing",
                        rise_cnt - last_rise, RES_RISES);
                end
                last_rise = rise_cnt;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected result", 1, 0);
                end else begin
                    logic [NCH*24-1:0] item;
                    item = exp_q.pop_front();
                    for (int ch = 0; ch < NCH; ch++)
                        chk(sample[ch*32+8 +: 24] == item[ch*24 +: 24], cur_tag,
                            $sformatf("channel %0d value", ch),
                            longint'($signed(sample[ch*32+8 +: 24])),
                            longint'($signed(item[ch*24 +: 24])));
                end
            end
            prev_any = |valid;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bit ok;
        rst_n  = 1'b0;
        en     = 1'b0;
        sd_bit = '0;
        pat[0] = 0; pat[1] = 0; pat[2] = 0; pat[3] = 0;
        repeat (5) @(negedge clk);
        chk(mclk == 1'b0, "R1", "reset clock level", mclk, 0);
        chk(valid == '0, "R7", "reset strobes", valid, 0);
        chk(sample == '0, "R6", "reset words", 1, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(mclk == 1'b0 && valid == '0, "R9", "disabled quiet", mclk, 0);

        // phase 1: ones, zeros, 3-of-5, 1-of-5
        cur_tag = "R2 R3 R5";
        start(5'b11111, 5'b00000, 5'b00111, 5'b00001);
        push_exp(3);
        @(posedge mclk);
        ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (mclk != (((i / 4) % 2) == 0)) ok = 1'b0;
        end
        chk(ok, "R1", "clock duty 4 high 4 low", ok, 1);
        repeat (3) @(posedge valid[0]);

        // disable on the exact edge of the next emission
        repeat (RES_CYCLES - 1) @(posedge clk);
        @(negedge clk);
        en = 1'b0;
        ok = 1'b1;
        repeat (4500) begin
            @(negedge clk);
            if (mclk || (valid != '0)) ok = 1'b0;
        end
        chk(ok, "R9", "disable on emission edge", ok, 1);

        // phase 2: new patterns, restart timing, long constant run wraps integrators
        cur_tag = "R3 R9 R10";
        start(5'b01111, 5'b00011, 5'b11111, 5'b00000);
        push_exp(6);
        repeat (6) @(posedge valid[0]);
        @(negedge clk);
        en = 1'b0;
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "all results seen", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule